// File: doc/BRIEF.md
# Clock Controller Configuration Register Bank

This block is the software-visible storage of a clock controller. A word-wide register bus reaches a window of 32-bit configuration words: PLL control words, bus divider settings, peripheral clock settings and the remaining control words up to a fixed limit. Every word comes out of reset with a fixed value. Reads return the stored word one clock after the request. The block drives no real oscillator, divider or gate. It only stores the words and reports them back.

A few writes are reshaped before they are stored, so that software polling code sees the result it waits for. A PLL control word written with its enable bit set reports lock at once. The update-request bits in the DRAM configuration word and in the second DDR PLL word read back as already finished. Addresses above the storage limit hold nothing. Any access there raises a one-cycle error pulse.

Top module: `clkctl_regbank`

## Requirements
- R1: Accesses are whole 32-bit words. The word index is `addr[9:2]`, and address bits 1:0 are ignored.
- R2: After reset the words hold these values: byte offset 0x000 and 0x020 hold 0x00001000; 0x008 holds 0x00035514; 0x010, 0x018, 0x030, 0x038 and 0x048 hold 0x03006207; 0x028 and 0x02C hold 0x00041811; 0x034 holds 0x00001811; 0x040 holds 0x00000515; 0x04C holds 0x00001800; 0x054 holds 0x00001010; 0x058 holds 0x01000000; 0x0F0 holds 0x00000001; 0x0F8 holds 0x0CCCA000; 0x310 holds 0x0000000F. Every other word below 0x324 holds 0.
- R3: A write to a word below 0x324 that has no special rule stores the data unchanged. A later read returns it exactly, including bit 31 and bit 28.
- R4: The PLL words are at offsets 0x000, 0x008, 0x010, 0x018, 0x020, 0x028, 0x02C, 0x030, 0x034, 0x038, 0x040, 0x048 and 0x04C. When a write to one of them has bit 31 (enable) at 1, bit 28 (lock) is stored as 1. Otherwise bit 28 is stored as written.
- R5: A write to offset 0x04C always stores bit 30 as 0, and R4 also applies to it.
- R6: A write to offset 0x0F4 always stores bit 16 as 0. All other bits are stored as written.
- R7: A read at offset 0x324 or above returns 0. A write there changes no stored word.
- R8: `oob_err` is 1 in the cycle after an access at offset 0x324 or above, and 0 after any other cycle.
- R9: `rdata` is loaded one clock after each access (read or write) with the value the word held before that access, and it holds its value in cycles with no access.
- R10: The reset is synchronous and active low. One reset cycle restores every word, clears `rdata` and `oob_err`, and overrides a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read (with acc_en) |
| addr | input | 10 | Byte address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| oob_err | output | 1 | One-cycle pulse after an out-of-window access |

## Verification
A write access returns the word's previous contents on `rdata` in the same cycle that the reshaped value is stored. A single access therefore exercises both the read path and the write-shaping path at once. The bench provokes this with back-to-back writes to one word, and expects each write to return the value of the write before it. A following read must then show the shaped value. A reset cycle held together with a write checks that reset wins over the store.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam int WORD_W      = 32;
   localparam int ADDR_W      = 10;
   localparam int NUM_WORDS   = 'h324 / 4;

   localparam int BIT_ENABLE  = 31;
   localparam int BIT_LOCK    = 28;
   localparam int BIT_PLL_UPD = 30;
   localparam int BIT_DRAM_UPD = 16;

   typedef enum logic [1:0] {
      WK_PLAIN,
      WK_PLL,
      WK_PLL_UPD,
      WK_DRAM_CFG
   } word_kind_e;

   function automatic word_kind_e kind_of(input int idx);
      case (idx)
         0, 2, 4, 6, 8, 10, 11, 12, 13, 14, 16, 18: kind_of = WK_PLL;
         19:                                        kind_of = WK_PLL_UPD;
         61:                                        kind_of = WK_DRAM_CFG;
         default:                                   kind_of = WK_PLAIN;
      endcase
   endfunction

   function automatic logic [WORD_W-1:0] reset_of(input int idx);
      case (idx)
         0, 8:                  reset_of = 32'h0000_1000;
         2:                     reset_of = 32'h0003_5514;
         4, 6, 12, 14, 18:      reset_of = 32'h0300_6207;
         10, 11:                reset_of = 32'h0004_1811;
         13:                    reset_of = 32'h0000_1811;
         16:                    reset_of = 32'h0000_0515;
         19:                    reset_of = 32'h0000_1800;
         21:                    reset_of = 32'h0000_1010;
         22:                    reset_of = 32'h0100_0000;
         60:                    reset_of = 32'h0000_0001;
         62:                    reset_of = 32'h0CCC_A000;
         196:                   reset_of = 32'h0000_000F;
         default:               reset_of = '0;
      endcase
   endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec #(
   parameter int ADDR_W    = clkctl_pkg::ADDR_W,
   parameter int NUM_WORDS = clkctl_pkg::NUM_WORDS,
   localparam int IDX_W    = ADDR_W - 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              in_range
);

   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("clkctl_addr_dec: ADDR_W too small");
   end
   if (NUM_WORDS > (1 << IDX_W) || NUM_WORDS < 1) begin : g_bad_words
      $error("clkctl_addr_dec: NUM_WORDS does not fit the window");
   end

   assign idx      = addr[ADDR_W-1:2];
   assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_WORDS));

endmodule

// File: rtl/clkctl_word.sv
module clkctl_word #(
   parameter int                     WORD_W  = clkctl_pkg::WORD_W,
   parameter clkctl_pkg::word_kind_e KIND    = clkctl_pkg::WK_PLAIN,
   parameter logic [WORD_W-1:0]      RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] q
);
   import clkctl_pkg::*;

   localparam logic [WORD_W-1:0] M_LOCK = WORD_W'(1) << BIT_LOCK;
   localparam logic [WORD_W-1:0] M_PUPD = WORD_W'(1) << BIT_PLL_UPD;
   localparam logic [WORD_W-1:0] M_DUPD = WORD_W'(1) << BIT_DRAM_UPD;

   if (WORD_W <= BIT_ENABLE) begin : g_bad_width
      $error("clkctl_word: WORD_W must cover the enable bit");
   end

   logic [WORD_W-1:0] shaped;

   if (KIND == WK_PLL) begin : g_pll
      always_comb shaped = wdata | (wdata[BIT_ENABLE] ? M_LOCK : '0);
   end else if (KIND == WK_PLL_UPD) begin : g_pll_upd
      always_comb shaped = (wdata & ~M_PUPD) | (wdata[BIT_ENABLE] ? M_LOCK : '0);
   end else if (KIND == WK_DRAM_CFG) begin : g_dram
      always_comb shaped = wdata & ~M_DUPD;
   end else begin : g_plain
      always_comb shaped = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RST_VAL;
      else if (we) q <= shaped;
   end

endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux #(
   parameter int WORD_W    = clkctl_pkg::WORD_W,
   parameter int NUM_WORDS = clkctl_pkg::NUM_WORDS,
   parameter int IDX_W     = 8
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
   input  logic [IDX_W-1:0]                 idx,
   input  logic                             in_range,
   output logic [WORD_W-1:0]                dout
);

   always_comb begin
      dout = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (in_range && idx == IDX_W'(i)) dout = words[i];
      end
   end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
   parameter int WORD_W    = clkctl_pkg::WORD_W,
   parameter int ADDR_W    = clkctl_pkg::ADDR_W,
   parameter int NUM_WORDS = clkctl_pkg::NUM_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              oob_err
);
   localparam int IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0]                 idx;
   logic                             in_range;
   logic [NUM_WORDS-1:0][WORD_W-1:0] words;
   logic [WORD_W-1:0]                rd_word;

   clkctl_addr_dec #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) i_dec (
      .addr(addr), .idx(idx), .in_range(in_range)
   );

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      logic we_i;
      assign we_i = acc_en && wr_en && in_range && (idx == IDX_W'(i));
      clkctl_word #(
         .WORD_W (WORD_W),
         .KIND   (clkctl_pkg::kind_of(i)),
         .RST_VAL(WORD_W'(clkctl_pkg::reset_of(i)))
      ) i_word (
         .clk(clk), .rst_n(rst_n), .we(we_i), .wdata(wdata), .q(words[i])
      );
   end

   clkctl_rd_mux #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) i_mux (
      .words(words), .idx(idx), .in_range(in_range), .dout(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata   <= '0;
         oob_err <= 1'b0;
      end else begin
         oob_err <= acc_en && !in_range;
         if (acc_en) rdata <= rd_word;
      end
   end

endmodule

// File: rtl/clkctl_regbank_chk.sv
module clkctl_regbank_chk #(
   parameter int WORD_W    = clkctl_pkg::WORD_W,
   parameter int ADDR_W    = clkctl_pkg::ADDR_W,
   parameter int NUM_WORDS = clkctl_pkg::NUM_WORDS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [WORD_W-1:0] wdata,
   input logic [WORD_W-1:0] rdata,
   input logic              oob_err
);
   import clkctl_pkg::*;

   logic       oob;
   word_kind_e kind;
   logic       rd_after_wr;

   assign oob  = int'(addr[ADDR_W-1:2]) >= NUM_WORDS;
   assign kind = kind_of(int'(addr[ADDR_W-1:2]));

   // Read now, write to the same word in the previous cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) rd_after_wr <= 1'b0;
      else        rd_after_wr <= acc_en && wr_en;
   end

   a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && oob) |=> oob_err);

   a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && oob) |=> !oob_err);

   a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && oob) |=> (rdata == '0));

   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |=> $stable(rdata));

   a_r4_lock_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && rd_after_wr && $past(wdata[BIT_ENABLE]) &&
       addr == $past(addr) && (kind == WK_PLL || kind == WK_PLL_UPD))
      |=> rdata[BIT_LOCK]);

   a_r5_pll_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && rd_after_wr && addr == $past(addr) && kind == WK_PLL_UPD)
      |=> !rdata[BIT_PLL_UPD]);

   a_r6_dram_upd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && rd_after_wr && addr == $past(addr) && kind == WK_DRAM_CFG)
      |=> !rdata[BIT_DRAM_UPD]);

   a_r10_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (rdata == '0 && !oob_err));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
   .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)
) i_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .rdata(rdata), .oob_err(oob_err)
);

// File: tb/test_clkctl_regbank.sv
module test_clkctl_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   typedef struct packed {
      logic [9:0]  waddr;
      logic [9:0]  raddr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [3:0]  rq;
   } vec_t;

   // R1 R3 R4 R5 R6 R7 write-then-read vectors
   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{10'h000, 10'h000, 32'h8000_0000, 32'h9000_0000, 4'd4},
      '{10'h000, 10'h000, 32'h0000_0000, 32'h0000_0000, 4'd4},
      '{10'h010, 10'h010, 32'h1000_0000, 32'h1000_0000, 4'd4},
      '{10'h048, 10'h048, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd4},
      '{10'h04C, 10'h04C, 32'hC000_0000, 32'h9000_0000, 4'd5},
      '{10'h04C, 10'h04C, 32'h4000_0000, 32'h0000_0000, 4'd5},
      '{10'h0F4, 10'h0F4, 32'h0001_FFFF, 32'h0000_FFFF, 4'd6},
      '{10'h054, 10'h054, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd3},
      '{10'h044, 10'h044, 32'h8000_0000, 32'h8000_0000, 4'd3},
      '{10'h320, 10'h320, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd3},
      '{10'h0FB, 10'h0F8, 32'h1234_5678, 32'h1234_5678, 4'd1},
      '{10'h324, 10'h324, 32'h1111_1111, 32'h0000_0000, 4'd7},
      '{10'h3FC, 10'h3FC, 32'h2222_2222, 32'h0000_0000, 4'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [9:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        oob_err;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkctl_regbank i_clkctl_regbank (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .oob_err(oob_err)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [9:0] a, input logic [31:0] d);
      acc_en = 1'b1; wr_en = wr; addr = a; wdata = d;
      @(negedge clk);
      acc_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string rq, input logic [9:0] a, input logic [31:0] exp);
      access(1'b0, a, '0);
      chk(rq, rdata, exp);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 rdata in reset", rdata, '0);
      chk("R10 err in reset", {31'b0, oob_err}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset values
      rd_chk("R2 0x000", 10'h000, 32'h0000_1000);
      rd_chk("R2 0x008", 10'h008, 32'h0003_5514);
      rd_chk("R2 0x018", 10'h018, 32'h0300_6207);
      rd_chk("R2 0x02C", 10'h02C, 32'h0004_1811);
      rd_chk("R2 0x040", 10'h040, 32'h0000_0515);
      rd_chk("R2 0x04C", 10'h04C, 32'h0000_1800);
      rd_chk("R2 0x058", 10'h058, 32'h0100_0000);
      rd_chk("R2 0x0F0", 10'h0F0, 32'h0000_0001);
      rd_chk("R2 0x0F8", 10'h0F8, 32'h0CCC_A000);
      rd_chk("R2 0x310", 10'h310, 32'h0000_000F);
      rd_chk("R2 0x004 zero", 10'h004, 32'h0000_0000);

      for (int i = 0; i < NV; i++) begin
         access(1'b1, VECS[i].waddr, VECS[i].wdata);
         chk($sformatf("R8 err after write vec%0d", i), {31'b0, oob_err},
             {31'b0, (VECS[i].waddr >= 10'h324)});
         rd_chk($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].raddr, VECS[i].exp);
      end

      // R7 out-of-window write left the last word intact
      rd_chk("R7 0x320 intact", 10'h320, 32'hA5A5_A5A5);

      // R8 pulse lasts one cycle
      access(1'b0, 10'h3A0, '0);
      chk("R8 err on oob read", {31'b0, oob_err}, 32'd1);
      @(negedge clk);
      chk("R8 err one cycle", {31'b0, oob_err}, 32'd0);

      // R9 write returns old contents, idle holds
      access(1'b1, 10'h100, 32'h0000_AAAA);
      access(1'b1, 10'h100, 32'h0000_BBBB);
      chk("R9 write returns old", rdata, 32'h0000_AAAA);
      @(negedge clk);
      chk("R9 idle hold", rdata, 32'h0000_AAAA);
      access(1'b1, 10'h020, 32'h8000_0001);
      chk("R9 write returns old PLL", rdata, 32'h0000_1000);
      rd_chk("R4 0x020 lock", 10'h020, 32'h9000_0001);

      // R10 reset overrides a simultaneous write
      rst_n = 1'b0;
      access(1'b1, 10'h054, 32'hFFFF_0000);
      chk("R10 rdata cleared", rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R10 0x054 restored", 10'h054, 32'h0000_1010);
      rd_chk("R10 0x000 restored", 10'h000, 32'h0000_1000);
      rd_chk("R10 0x100 cleared", 10'h100, 32'h0000_0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule